// File: doc/BRIEF.md
# Decimal Subroutine Linkage Unit

This unit performs the call and return steps of a machine whose words hold six decimal digits (BCD, four bits per digit) and whose addresses hold three. A call takes a general register chosen by the program as the linkage register. It saves that register's old contents on a system stack in memory. It then writes the current instruction address into the register and loads the target address into the instruction address register. A return reverses this: the instruction address is taken from the linkage register, and the saved word is popped back into that register.

The stack sits in the low decimal region of memory, addresses 000 to 099, and grows downward from 099. The stack pointer lives inside the unit and is shown at a port. The register file, the memory array and the instruction address register all sit outside the unit. The unit reaches them through a combinational register read port, a register write port, an instruction address load port and a one-cycle synchronous memory port. Decoding the instruction that issues the command is done elsewhere. The unit never touches the condition flags.

Top module: `dec_link_unit`

## Requirements
- R1: After reset the stack pointer is 99, the stack error flag is 0, and busy and done are 0.
- R2: On a call, the old word of the linkage register is written to memory at the address equal to the stack pointer. The address is given as three BCD digits, least significant digit in bits 3:0. The stack pointer then drops by one.
- R3: On a call, the linkage register receives the current instruction address, with its upper three digits zero. The instruction address output receives the target address.
- R4: On a return, the instruction address output receives the three low digits of the linkage register. The stack pointer rises by one. The word read at the new pointer value is written back into the linkage register.
- R5: Nested calls may reuse the same linkage register. Returns in reverse order restore each return address and, at the end, the register's original word.
- R6: A call while the stack pointer is below zero sets the stack error flag. The stack pointer reads as -1 in two's complement after 100 pushes. No memory access, register write or instruction address load takes place, and done still pulses.
- R7: A return while the stack pointer is 99 sets the stack error flag. No memory access, register write or instruction address load takes place, and done still pulses.
- R8: The stack error flag stays set until reset. Later valid commands still run normally.
- R9: A command is taken on a clock edge where cmd_valid is high and busy is low. For a successful command, the memory access occupies the next cycle and done is high in the cycle after that. For an error, done is high in the cycle right after acceptance. Done is a one-cycle pulse, and commands presented while busy is high are ignored.
- R10: At most one memory access is active in any cycle, and every memory address lies in 000 to 099.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ret | input | 1 | 0 = call, 1 = return |
| cmd_reg | input | 3 | Linkage register index |
| cmd_target | input | 12 | Call target address, BCD |
| cur_iar | input | 12 | Current instruction address (next instruction), BCD |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Sequence complete pulse |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |
| sp_val | output | 8 | Stack pointer, two's complement binary |
| rf_rd_idx | output | 3 | Register read index |
| rf_rd_data | input | 24 | Register read data, combinational |
| rf_we | output | 1 | Register write enable |
| rf_wr_idx | output | 3 | Register write index |
| rf_wr_data | output | 24 | Register write data |
| iar_we | output | 1 | Instruction address load enable |
| iar_wdata | output | 12 | New instruction address, BCD |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable; data one cycle later |
| mem_addr | output | 12 | Memory address, BCD |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data |

## Verification
Some rules are checked on every cycle. These cover the stack pointer moving by exactly one around each push and pop, the bounds on memory addresses, the exclusion between reads and writes, the error flag never clearing, done lasting one cycle, and error commands causing no side effects. Other behaviours can only be shown by the bench's scenarios against its own model of the registers and memory. These are the last-in first-out order of nested calls through one register, the exact words that land in registers and memory, the 100-deep limit, and the latency in cycles.

// File: rtl/dec_link_unit.sv
module dec_link_unit #(
  parameter int DIGITS      = 6,
  parameter int ADDR_DIGITS = 3,
  parameter int NREGS       = 8,
  parameter int STACK_TOP   = 99,
  localparam int WORD_W = 4 * DIGITS,
  localparam int ADDR_W = 4 * ADDR_DIGITS,
  localparam int IDX_W  = $clog2(NREGS),
  localparam int SP_W   = $clog2(STACK_TOP + 2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_ret,
  input  logic [IDX_W-1:0]  cmd_reg,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic [ADDR_W-1:0] cur_iar,
  output logic              busy,
  output logic              done,
  output logic              stack_err,
  output logic [SP_W-1:0]   sp_val,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [WORD_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [WORD_W-1:0] rf_wr_data,
  output logic              iar_we,
  output logic [ADDR_W-1:0] iar_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_LINK, S_POP, S_RESTORE, S_ABORT
  } state_t;

  state_t                  state;
  logic signed [SP_W-1:0]  sp_q;
  logic                    err_q;
  logic [IDX_W-1:0]        r_idx;
  logic [ADDR_W-1:0]       r_tgt;
  logic [ADDR_W-1:0]       r_iar;
  logic [ADDR_W-1:0]       r_ret;

  function automatic logic [ADDR_W-1:0] to_bcd(input int v);
    logic [ADDR_W-1:0] o;
    int t;
    t = v;
    o = '0;
    for (int i = 0; i < ADDR_DIGITS; i++) begin
      o[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return o;
  endfunction

  wire accept     = cmd_valid && (state == S_IDLE);
  wire stack_full = sp_q[SP_W-1];
  wire stack_empty = (int'(sp_q) == STACK_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sp_q  <= SP_W'(STACK_TOP);
      err_q <= 1'b0;
      r_idx <= '0;
      r_tgt <= '0;
      r_iar <= '0;
      r_ret <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          r_idx <= cmd_reg;
          r_tgt <= cmd_target;
          r_iar <= cur_iar;
          if (!cmd_ret) begin
            if (stack_full) begin
              err_q <= 1'b1;
              state <= S_ABORT;
            end else begin
              state <= S_PUSH;
            end
          end else begin
            if (stack_empty) begin
              err_q <= 1'b1;
              state <= S_ABORT;
            end else begin
              state <= S_POP;
            end
          end
        end
        S_PUSH: begin
          sp_q  <= sp_q - SP_W'(1);
          state <= S_LINK;
        end
        S_POP: begin
          sp_q  <= sp_q + SP_W'(1);
          r_ret <= rf_rd_data[ADDR_W-1:0];
          state <= S_RESTORE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_LINK) || (state == S_RESTORE) || (state == S_ABORT);
  assign stack_err = err_q;
  assign sp_val    = sp_q;

  assign rf_rd_idx  = r_idx;
  assign mem_we     = (state == S_PUSH);
  assign mem_re     = (state == S_POP);
  assign mem_addr   = to_bcd(mem_re ? int'(sp_q) + 1 : int'(sp_q));
  assign mem_wdata  = rf_rd_data;

  assign rf_we      = (state == S_LINK) || (state == S_RESTORE);
  assign rf_wr_idx  = r_idx;
  assign rf_wr_data = (state == S_LINK) ? {{(WORD_W-ADDR_W){1'b0}}, r_iar} : mem_rdata;
  assign iar_we     = rf_we;
  assign iar_wdata  = (state == S_LINK) ? r_tgt : r_ret;

  assert_access_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (!(mem_we && mem_re) && mem_addr[ADDR_W-1:8] == '0));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_q + SP_W'(1)) == $past(sp_q));

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_q == ($past(sp_q) + SP_W'(1)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_overflow_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !cmd_ret && sp_val[SP_W-1])
      |=> (stack_err && done && !mem_we && !rf_we && !iar_we));

  assert_underflow_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_ret && int'(sp_val) == STACK_TOP)
      |=> (stack_err && done && !mem_re && !rf_we && !iar_we));

endmodule

// File: tb/dec_link_unit_bench.sv
module dec_link_unit_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, cmd_ret = 0;
  logic [2:0]  cmd_reg = 0;
  logic [11:0] cmd_target = 0, cur_iar = 0;
  logic        busy, done, stack_err;
  logic [7:0]  sp_val;
  logic [2:0]  rf_rd_idx, rf_wr_idx;
  logic [23:0] rf_rd_data, rf_wr_data, mem_wdata;
  logic [23:0] mem_rdata = 0;
  logic        rf_we, iar_we, mem_we, mem_re;
  logic [11:0] iar_wdata, mem_addr;

  dec_link_unit u_dec_link_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ret(cmd_ret),
    .cmd_reg(cmd_reg), .cmd_target(cmd_target), .cur_iar(cur_iar),
    .busy(busy), .done(done), .stack_err(stack_err), .sp_val(sp_val),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .iar_we(iar_we),
    .iar_wdata(iar_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [23:0] rf [8];
  logic [23:0] mem [100];
  logic [11:0] iar_reg = 0;
  int acc_cnt = 0, wr_cnt = 0, done_cnt = 0;
  int total = 0, bad = 0;

  function automatic logic [11:0] bcd3(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction
  function automatic int unbcd(input logic [11:0] b);
    return int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    if (mem_we) mem[unbcd(mem_addr)] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[unbcd(mem_addr)];
    if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
    if (iar_we) iar_reg <= iar_wdata;
    if (mem_we || mem_re) acc_cnt <= acc_cnt + 1;
    if (rf_we || iar_we) wr_cnt <= wr_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 8; i++) rf[i] = 24'h000500 + 24'(i);
    for (int i = 0; i < 100; i++) mem[i] = 24'h0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_cmd(input bit ret, input int idx, input int tgt, input int iar, output int lat);
    @(negedge clk);
    cmd_valid = 1; cmd_ret = ret; cmd_reg = 3'(idx);
    cmd_target = bcd3(tgt); cur_iar = bcd3(iar);
    @(negedge clk);
    cmd_valid = 0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        ret;
    logic [2:0]  idx;
    logic [11:0] tgt;
    logic [11:0] iar;
    logic [11:0] exp_iar;
    logic [23:0] exp_reg;
    logic [7:0]  exp_sp;
    logic [23:0] exp_push;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 3'd5, 12'h300, 12'h101, 12'h300, 24'h000101, 8'd98, 24'h000505},
    '{1'b0, 3'd5, 12'h400, 12'h301, 12'h400, 24'h000301, 8'd97, 24'h000101},
    '{1'b0, 3'd2, 12'h450, 12'h401, 12'h450, 24'h000401, 8'd96, 24'h000502},
    '{1'b1, 3'd2, 12'h000, 12'h000, 12'h401, 24'h000502, 8'd97, 24'h000000},
    '{1'b1, 3'd5, 12'h000, 12'h000, 12'h301, 24'h000101, 8'd98, 24'h000000},
    '{1'b1, 3'd5, 12'h000, 12'h000, 12'h101, 24'h000505, 8'd99, 24'h000000}
  };

  bit timed_out = 0;
  initial begin
    repeat (100000) @(posedge clk);
    timed_out = 1;
  end
  initial begin
    wait (timed_out);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, a0, w0, d0;
    do_reset();
    chk(sp_val == 8'd99 && !stack_err && !busy && !done, "R1 reset state",
        {16'h0, sp_val, 5'h0, stack_err, busy, done}, {16'h0, 8'd99, 8'h0});

    for (int v = 0; v < 6; v++) begin
      run_cmd(VECS[v].ret, int'(VECS[v].idx), unbcd(VECS[v].tgt), unbcd(VECS[v].iar), lat);
      chk(iar_reg == VECS[v].exp_iar, VECS[v].ret ? "R4 return IAR" : "R3 call IAR", 32'(iar_reg), 32'(VECS[v].exp_iar));
      chk(rf[VECS[v].idx] == VECS[v].exp_reg, VECS[v].ret ? "R5 restored register" : "R3 link register",
          32'(rf[VECS[v].idx]), 32'(VECS[v].exp_reg));
      chk(sp_val == VECS[v].exp_sp, VECS[v].ret ? "R4 pointer rise" : "R2 pointer drop", 32'(sp_val), 32'(VECS[v].exp_sp));
      if (!VECS[v].ret)
        chk(mem[VECS[v].exp_sp + 1] == VECS[v].exp_push, "R2 pushed word",
            32'(mem[VECS[v].exp_sp + 1]), 32'(VECS[v].exp_push));
      chk(lat == 1, "R9 success latency", 32'(lat), 32'd1);
    end

    a0 = acc_cnt; w0 = wr_cnt;
    run_cmd(1, 3, 0, 0, lat);
    chk(stack_err, "R7 underflow flag", 32'(stack_err), 32'd1);
    chk(acc_cnt == a0 && wr_cnt == w0, "R7 no side effects", 32'(acc_cnt - a0 + wr_cnt - w0), 32'd0);
    chk(sp_val == 8'd99 && rf[3] == 24'h000503, "R7 state kept", 32'(sp_val), 32'd99);
    chk(lat == 0, "R9 error latency", 32'(lat), 32'd0);

    run_cmd(0, 4, 700, 123, lat);
    chk(stack_err, "R8 flag sticky", 32'(stack_err), 32'd1);
    chk(iar_reg == 12'h700 && rf[4] == 24'h000123 && mem[99] == 24'h000504, "R8 later call runs",
        32'(iar_reg), 32'h700);

    do_reset();
    chk(!stack_err && sp_val == 8'd99, "R1 reset clears flag", 32'(stack_err), 32'd0);
    d0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1; cmd_ret = 0; cmd_reg = 3'd1; cmd_target = 12'h222; cur_iar = 12'h150;
    @(negedge clk);
    cmd_reg = 3'd3; cmd_target = 12'h333; cur_iar = 12'h160;
    @(negedge clk);
    cmd_valid = 0;
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 busy command ignored", 32'(done_cnt - d0), 32'd1);
    chk(sp_val == 8'd98 && rf[3] == 24'h000503 && rf[1] == 24'h000150, "R9 only first command",
        32'(rf[3]), 32'h000503);

    do_reset();
    for (int i = 0; i < 100; i++) run_cmd(0, 0, 200, 100 + i, lat);
    chk(sp_val == 8'hFF && !stack_err, "R6 full depth reached", 32'(sp_val), 32'hFF);
    chk(mem[0] == 24'h000198, "R2 deepest push at 000", 32'(mem[0]), 32'h000198);
    a0 = acc_cnt; w0 = wr_cnt;
    run_cmd(0, 0, 300, 555, lat);
    chk(stack_err, "R6 overflow flag", 32'(stack_err), 32'd1);
    chk(acc_cnt == a0 && wr_cnt == w0 && rf[0] == 24'h000199, "R6 no side effects",
        32'(rf[0]), 32'h000199);
    chk(sp_val == 8'hFF, "R6 pointer held", 32'(sp_val), 32'hFF);
    run_cmd(1, 0, 0, 0, lat);
    chk(iar_reg == 12'h199 && rf[0] == 24'h000198 && sp_val == 8'd0, "R4 pop from 000",
        32'(rf[0]), 32'h000198);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule